// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host access to a 256-entry byte-wide configuration space through only two adjacent I/O byte addresses. The lower address is the pointer port. A byte written there selects an entry. The upper address is the value port. A byte written there updates the selected entry, unless that entry's protection rule refuses the value. A read at either address returns the selected entry. The read result arrives one clock after the read strobe as a single-cycle pulse on `rd_valid`.

An external enable, `win_en`, opens and closes the whole window. Its source is one bit of a control byte held elsewhere. While it is low, the block ignores every access. Most of the space is read-only. A few entries accept any byte. Two entries are keyed: each accepts one fixed value and discards every other value. There is no back-pressure. The consumer must take `rd_data` in the cycle `rd_valid` is high, and `rd_data` is zero in every other cycle.

Top module: `cfg_window_port`

## Requirements
- R1: Reset behaviour:
  - The pointer resets to 0x00.
  - Entries reset to these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE.
  - Every other entry resets to 0x00.
  - `rd_valid` and `rd_data` are low after reset.
- R2: A write to address BASE_ADDR (0x03F0), while the window is enabled, loads `bus_wdata` into the pointer in that clock edge.
- R3: A write to BASE_ADDR+1 while the window is enabled stores the full byte, in that clock edge, when the pointer selects a free entry. The free entries are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R4: A write to BASE_ADDR+1 leaves the selected entry unchanged when the pointer is in any of these ranges: 0x00–0xDF, 0xE4–0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF.
- R5: Entry 0xE7 changes only when the value written is 0xFE. Entry 0xE8 changes only when the value written is 0xBE. Any other value written to either entry is dropped.
- R6: A read strobe at either window address, while enabled, gives `rd_valid`=1 in the next cycle. In that cycle `rd_data` holds the entry the pointer selected at the strobe. `rd_data` is 0x00 whenever `rd_valid` is 0.
- R7: While `win_en` is low:
  - writes change neither the pointer nor any entry;
  - reads give no `rd_valid`;
  - `rd_data` stays 0x00.
- R8: Accesses to any address other than the two window addresses have no effect and produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Window enable, from an external control bit |
| bus_wr | input | 1 | Single-byte write strobe |
| bus_rd | input | 1 | Single-byte read strobe |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 8 | Registered read data, zero when not valid |

## Verification
The checker tests on every cycle:
- the read-pulse timing;
- that `rd_data` is zero outside a read pulse;
- the silence of a disabled window;
- pointer loading;
- that protected and keyed entries stay stable after a refused write.

Which entries are free, which are locked and which are keyed across the whole index range can be shown only by the bench. The same holds for the reset image of all 256 entries and for the full value sweeps on the keyed entries. The bench sweeps every index and every data value on the keyed entries, and predicts each readback from the requirement lists.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  typedef logic [7:0] cfg_byte_t;

  localparam int unsigned IDX_W = 8;
  localparam int unsigned N_ENT = 1 << IDX_W;

  localparam cfg_byte_t KEY_IDX_A = 8'hE7;
  localparam cfg_byte_t KEY_VAL_A = 8'hFE;
  localparam cfg_byte_t KEY_IDX_B = 8'hE8;
  localparam cfg_byte_t KEY_VAL_B = 8'hBE;

  // Power-on image of one entry.
  function automatic cfg_byte_t entry_default(input cfg_byte_t idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      KEY_IDX_A: return KEY_VAL_A;
      KEY_IDX_B: return KEY_VAL_B;
      default: return 8'h00;
    endcase
  endfunction

  // True for entries that never accept a write.
  function automatic logic entry_locked(input cfg_byte_t idx);
    if (idx <= 8'hDF) return 1'b1;
    case (idx)
      8'hE4, 8'hE5, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_window_decode.sv
module cfg_window_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ptr,
  output logic              hit_val
);
  localparam logic [ADDR_W-1:0] VAL_ADDR = BASE_ADDR + 1'b1;

  assign hit_ptr = (addr == BASE_ADDR);
  assign hit_val = (addr == VAL_ADDR);
endmodule

// File: rtl/cfg_write_filter.sv
module cfg_write_filter
  import cfg_window_pkg::*;
(
  input  cfg_byte_t idx,
  input  cfg_byte_t wdata,
  output logic      accept
);
  logic keyed_a, keyed_b;

  assign keyed_a = (idx == KEY_IDX_A);
  assign keyed_b = (idx == KEY_IDX_B);

  always_comb begin
    if (entry_locked(idx))  accept = 1'b0;
    else if (keyed_a)       accept = (wdata == KEY_VAL_A);
    else if (keyed_b)       accept = (wdata == KEY_VAL_B);
    else                    accept = 1'b1;
  end
endmodule

// File: rtl/cfg_entry_store.sv
module cfg_entry_store
  import cfg_window_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  cfg_byte_t idx,
  input  cfg_byte_t wdata,
  output cfg_byte_t sel
);
  cfg_byte_t ent [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_ENT); i++) ent[i] <= entry_default(cfg_byte_t'(i));
    end else if (we) begin
      ent[idx] <= wdata;
    end
  end

  assign sel = ent[idx];
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic      hit_ptr, hit_val, accept, ent_we;
  cfg_byte_t idx_q, sel_entry;

  cfg_window_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .hit_ptr(hit_ptr), .hit_val(hit_val)
  );

  cfg_write_filter u_flt (
    .idx(idx_q), .wdata(bus_wdata), .accept(accept)
  );

  assign ent_we = win_en && bus_wr && hit_val && accept;

  cfg_entry_store u_store (
    .clk(clk), .rst_n(rst_n), .we(ent_we), .idx(idx_q),
    .wdata(bus_wdata), .sel(sel_entry)
  );

  // Pointer register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           idx_q <= '0;
    else if (win_en && bus_wr && hit_ptr) idx_q <= bus_wdata;
  end

  // Registered read port; value reflects state before a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (win_en && bus_rd && (hit_ptr || hit_val)) begin
      rd_valid <= 1'b1;
      rd_data  <= sel_entry;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic [7:0]        idx_q,
  input logic [7:0]        sel_entry
);
  logic at_ptr, at_val;
  assign at_ptr = (bus_addr == BASE_ADDR);
  assign at_val = (bus_addr == BASE_ADDR + 1'b1);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bus_wr && at_ptr) |=> (idx_q == $past(bus_wdata)));

  // R3
  free_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bus_wr && at_val && idx_q == 8'hE0) |=> (sel_entry == $past(bus_wdata)));

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bus_wr && at_val && idx_q <= 8'hDF) |=> (sel_entry == $past(sel_entry)));

  // R5
  key_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bus_wr && at_val && idx_q == 8'hE7 && bus_wdata != 8'hFE)
      |=> (sel_entry == $past(sel_entry)));

  // R6
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bus_rd && (at_ptr || at_val)) |=> rd_valid);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 8'h00));

  // R7
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> (!rd_valid && idx_q == $past(idx_q)));
endmodule

bind cfg_window_port cfg_window_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_en(win_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .idx_q(idx_q), .sel_entry(sel_entry)
);

// File: tb/sim_cfg_window_port.sv
module sim_cfg_window_port;
  localparam logic [15:0] BASE = 16'h03F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  cfg_window_port #(.ADDR_W(16), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      'hE0: return 8'h3C;  'hE2: return 8'h03;  'hE3: return 8'hFC;
      'hE6: return 8'hDE;  'hE7: return 8'hFE;  'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_locked(input int i);
    return (i <= 'hDF) || (i inside {'hE4, 'hE5, ['hE9:'hED], 'hF3, 'hF5, 'hF7,
                                     ['hF9:'hFB], ['hFD:'hFF]});
  endfunction

  function automatic void model_write(input int i, input logic [7:0] v);
    if (is_locked(i)) return;
    if (i == 'hE7 && v != 8'hFE) return;
    if (i == 'hE8 && v != 8'hBE) return;
    model[i] = v;
  endfunction

  task automatic chk(input string req, input bit ok, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic v, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic rd_expect(input string req, input logic [15:0] a, input logic [7:0] e);
    logic v; logic [7:0] d;
    rd(a, v, d);
    chk(req, v && d == e, {v, d}, {1'b1, e});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic v; logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = rst_val(i);
    repeat (3) @(negedge clk);
    // R1 outputs quiet in and after reset
    chk("R1", rd_valid == 1'b0 && rd_data == 8'h00, {rd_valid, rd_data}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    win_en = 1'b1;
    // R1 pointer starts at 0: read without loading it
    rd_expect("R1", BASE + 16'd1, model[0]);

    // R1 full reset image
    for (int i = 0; i < 256; i++) begin
      wr(BASE, 8'(i));
      rd_expect("R1", BASE + 16'd1, model[i]);
    end

    // R2 R3 R4 R5: pattern write at every index, read back at the pointer address (R6)
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      p = 8'(i) ^ 8'hA5;
      wr(BASE, 8'(i));
      wr(BASE + 16'd1, p);
      model_write(i, p);
      rd_expect(is_locked(i) ? "R4" : "R3", BASE, model[i]);
    end

    // R5 full value sweeps on the keyed entries
    for (int k = 0; k < 2; k++) begin
      int ki;
      ki = (k == 0) ? 'hE7 : 'hE8;
      for (int v2 = 0; v2 < 256; v2++) begin
        wr(BASE, 8'(ki));
        wr(BASE + 16'd1, 8'(v2));
        model_write(ki, 8'(v2));
        rd_expect("R5", (v2 % 2 == 0) ? BASE : BASE + 16'd1, model[ki]);
      end
    end

    // R3 full byte on a free entry
    for (int v2 = 0; v2 < 256; v2++) begin
      wr(BASE, 8'hEE);
      wr(BASE + 16'd1, 8'(v2));
      model_write('hEE, 8'(v2));
      rd_expect("R3", BASE + 16'd1, model['hEE]);
    end

    // R7 closed window: pointer sits at EE
    win_en = 1'b0;
    wr(BASE, 8'hE0);
    wr(BASE + 16'd1, 8'h11);
    rd(BASE, v, d);
    chk("R7", !v && d == 8'h00, {v, d}, 9'h000);
    rd(BASE + 16'd1, v, d);
    chk("R7", !v && d == 8'h00, {v, d}, 9'h000);
    win_en = 1'b1;
    rd_expect("R7", BASE, model['hEE]);
    wr(BASE, 8'hE0);
    rd_expect("R7", BASE, model['hE0]);

    // R8 neighbouring addresses ignored
    wr(BASE + 16'd2, 8'hE1);
    wr(BASE - 16'd1, 8'h77);
    rd(BASE + 16'd2, v, d);
    chk("R8", !v && d == 8'h00, {v, d}, 9'h000);
    rd_expect("R8", BASE, model['hE0]);

    // R6 data returns to zero the cycle after the pulse
    rd(BASE, v, d);
    @(negedge clk);
    chk("R6", !rd_valid && rd_data == 8'h00, {rd_valid, rd_data}, 9'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule